// File: doc/BRIEF.md
# Sensor Message Packet Framer

The framer wraps externally produced sensor payloads into binary packets ready for a byte-serial transmitter. A request carries a two-bit message kind and a payload byte count; once accepted, the block emits two sync bytes, a message identifier byte, a count byte, the payload bytes pulled from a separate input stream, and a trailing two-byte Fletcher checksum. The checksum is accumulated while the bytes go out, so no packet storage is needed.

Three kinds are produced: navigation sensor data, navigation position/velocity, and GPS position/velocity. For the two position/velocity kinds the framer appends one status byte after the caller's payload. That byte states that position is latitude/longitude/altitude and that velocity is east/north/up in cm/s. The GPS kind also flags a 3D fix. The count byte includes this status byte. Output is a byte-wide valid/ready stream that stalls without loss, so a UART transmitter with a small FIFO can sit directly downstream.

Top module: `sensor_pkt_framer`

## Requirements
- R1: After reset, out_valid and pay_ready are low and req_ready is high.
- R2: An accepted frame is emitted in this order: sync byte 0x81, sync byte 0xA1, identifier, count, payload bytes in arrival order, optional status byte, checksum byte 1, checksum byte 2.
- R3: req_kind 0 gives identifier 0x01 (navigation sensor), 1 gives 0x02 (navigation position/velocity) and 2 gives 0x03 (GPS position/velocity). req_kind 3 is consumed and produces no output byte.
- R4: For req_kind 1 and 2 one status byte follows the payload, and count = req_len + 1. Status bit 0 means position is lat/lon/alt and bit 1 means velocity is east/north/up in cm/s, giving 0x03 for kind 1. Bit 2 marks a 3D fix, giving 0x07 for kind 2. For kind 0 there is no status byte and count = req_len.
- R5: The checksum covers identifier, count, payload and status bytes. For each byte in order, s1 = (s1 + byte) mod 256 and then s2 = (s2 + s1) mod 256, both starting at 0. s1 is sent first, then s2.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_last keep their values, and no byte is lost or repeated.
- R7: With req_len 0, kind 0 emits the four header bytes followed directly by the checksum. Kinds 1 and 2 emit the header, the status byte and then the checksum.
- R8: req_ready is low from the cycle after a request is accepted until the final checksum byte has been taken by the consumer.
- R9: out_last is high on the final checksum byte and on no other byte.
- R10: A request of kind 1 or 2 with req_len 255 is consumed and produces no output byte, because the count would not fit in one byte.
- R11: pay_ready is high only while the framer is in its payload phase and the output register can take a byte in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Framer idle and can accept a request |
| req_kind | input | 2 | Message kind: 0 nav sensor, 1 nav pos/vel, 2 GPS pos/vel |
| req_len | input | 8 | Number of payload bytes the caller will supply |
| pay_valid | input | 1 | Payload byte present |
| pay_ready | output | 1 | Payload byte taken this cycle |
| pay_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the final checksum byte |

## Verification
The bound checker watches the stream rules on every cycle. It checks that a stalled byte is held unchanged, that out_last never appears without out_valid, that payload is taken only when the output register can absorb it, that no request is taken while a frame is in flight, and that every frame opens with the two sync bytes. Identifier choice, count adjustment, status values, checksum arithmetic, rejected requests and the zero-length layout depend on whole frames. Only the bench scenarios show these: a scoreboard compares every emitted byte against a frame computed independently, under random back-pressure and gaps in the payload stream.

// File: rtl/sensor_pkt_pkg.sv
package sensor_pkt_pkg;

    localparam int BYTE_W = 8;
    localparam int KIND_W = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [KIND_W-1:0] {
        KIND_NAV_SENSOR = 2'd0,
        KIND_NAV_PV     = 2'd1,
        KIND_GPS_PV     = 2'd2,
        KIND_BAD        = 2'd3
    } kind_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SYNC0,
        PH_SYNC1,
        PH_ID,
        PH_CNT,
        PH_PAY,
        PH_STAT,
        PH_CK1,
        PH_CK2
    } phase_e;

    // status bit positions
    localparam int STAT_POS_LLA = 0;
    localparam int STAT_VEL_ENU = 1;
    localparam int STAT_FIX_3D  = 2;

    typedef struct packed {
        phase_e phase;
        kind_e  kind;
        logic   has_stat;
        byte_t  cnt;
        byte_t  rem;
        logic   ov;
        byte_t  od;
        logic   olast;
    } frm_state_t;

    typedef struct packed {
        byte_t s1;
        byte_t s2;
    } sum_state_t;

    function automatic logic kind_has_status(kind_e k);
        return (k == KIND_NAV_PV) || (k == KIND_GPS_PV);
    endfunction

    function automatic byte_t status_for(kind_e k);
        byte_t s;
        s = '0;
        if (kind_has_status(k)) begin
            s[STAT_POS_LLA] = 1'b1;
            s[STAT_VEL_ENU] = 1'b1;
        end
        if (k == KIND_GPS_PV) begin
            s[STAT_FIX_3D] = 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/pkt_fletcher_acc.sv
module pkt_fletcher_acc
    import sensor_pkt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  add_en,
    input  byte_t add_byte,
    output byte_t sum1,
    output byte_t sum2
);

    sum_state_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (add_en) begin
            acc_d.s1 = acc_q.s1 + add_byte;
            acc_d.s2 = acc_q.s2 + acc_q.s1 + add_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign sum1 = acc_q.s1;
    assign sum2 = acc_q.s2;

endmodule

// File: rtl/pkt_req_check.sv
module pkt_req_check
    import sensor_pkt_pkg::*;
(
    input  kind_e kind,
    input  byte_t len,
    output logic  ok,
    output logic  has_stat,
    output byte_t cnt
);

    localparam byte_t LEN_MAX = {BYTE_W{1'b1}};

    always_comb begin
        has_stat = kind_has_status(kind);
        cnt      = len + {{(BYTE_W-1){1'b0}}, has_stat};
        ok       = (kind != KIND_BAD) && !(has_stat && (len == LEN_MAX));
    end

endmodule

// File: rtl/pkt_byte_select.sv
module pkt_byte_select
    import sensor_pkt_pkg::*;
#(
    parameter byte_t SYNC_A        = 8'h81,
    parameter byte_t SYNC_B        = 8'hA1,
    parameter byte_t ID_NAV_SENSOR = 8'h01,
    parameter byte_t ID_NAV_PV     = 8'h02,
    parameter byte_t ID_GPS_PV     = 8'h03
) (
    input  phase_e phase,
    input  kind_e  kind,
    input  byte_t  cnt,
    input  byte_t  pay_byte,
    input  byte_t  sum1,
    input  byte_t  sum2,
    output byte_t  byte_o,
    output logic   cover_o,
    output logic   last_o
);

    byte_t id_byte;

    always_comb begin
        unique case (kind)
            KIND_NAV_SENSOR: id_byte = ID_NAV_SENSOR;
            KIND_NAV_PV:     id_byte = ID_NAV_PV;
            KIND_GPS_PV:     id_byte = ID_GPS_PV;
            default:         id_byte = '0;
        endcase
    end

    always_comb begin
        byte_o  = '0;
        cover_o = 1'b0;
        last_o  = 1'b0;
        case (phase)
            PH_SYNC0: byte_o = SYNC_A;
            PH_SYNC1: byte_o = SYNC_B;
            PH_ID: begin
                byte_o  = id_byte;
                cover_o = 1'b1;
            end
            PH_CNT: begin
                byte_o  = cnt;
                cover_o = 1'b1;
            end
            PH_PAY: begin
                byte_o  = pay_byte;
                cover_o = 1'b1;
            end
            PH_STAT: begin
                byte_o  = status_for(kind);
                cover_o = 1'b1;
            end
            PH_CK1: byte_o = sum1;
            PH_CK2: begin
                byte_o = sum2;
                last_o = 1'b1;
            end
            default: byte_o = '0;
        endcase
    end

endmodule

// File: rtl/sensor_pkt_framer.sv
module sensor_pkt_framer
    import sensor_pkt_pkg::*;
#(
    parameter byte_t SYNC_A        = 8'h81,
    parameter byte_t SYNC_B        = 8'hA1,
    parameter byte_t ID_NAV_SENSOR = 8'h01,
    parameter byte_t ID_NAV_PV     = 8'h02,
    parameter byte_t ID_GPS_PV     = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [BYTE_W-1:0] req_len,
    input  logic              pay_valid,
    output logic              pay_ready,
    input  logic [BYTE_W-1:0] pay_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last
);

    frm_state_t st_d, st_q;

    logic  req_ok, req_has_stat;
    byte_t req_cnt;
    byte_t sel_byte;
    logic  sel_cover, sel_last;
    byte_t sum1, sum2;
    logic  slot_free, fire, acc_clr;

    pkt_req_check u_req (
        .kind     (kind_e'(req_kind)),
        .len      (req_len),
        .ok       (req_ok),
        .has_stat (req_has_stat),
        .cnt      (req_cnt)
    );

    pkt_byte_select #(
        .SYNC_A        (SYNC_A),
        .SYNC_B        (SYNC_B),
        .ID_NAV_SENSOR (ID_NAV_SENSOR),
        .ID_NAV_PV     (ID_NAV_PV),
        .ID_GPS_PV     (ID_GPS_PV)
    ) u_sel (
        .phase    (st_q.phase),
        .kind     (st_q.kind),
        .cnt      (st_q.cnt),
        .pay_byte (pay_data),
        .sum1     (sum1),
        .sum2     (sum2),
        .byte_o   (sel_byte),
        .cover_o  (sel_cover),
        .last_o   (sel_last)
    );

    pkt_fletcher_acc u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acc_clr),
        .add_en   (fire && sel_cover),
        .add_byte (sel_byte),
        .sum1     (sum1),
        .sum2     (sum2)
    );

    // output register can take a new byte this cycle
    assign slot_free = !st_q.ov || out_ready;
    assign fire      = slot_free && (st_q.phase != PH_IDLE)
                       && ((st_q.phase != PH_PAY) || pay_valid);

    assign req_ready = (st_q.phase == PH_IDLE) && !st_q.ov;
    assign pay_ready = (st_q.phase == PH_PAY) && slot_free;
    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign out_last  = st_q.ov && st_q.olast;

    always_comb begin
        st_d    = st_q;
        acc_clr = 1'b0;

        if (st_q.ov && out_ready) begin
            st_d.ov = 1'b0;
        end

        if (fire) begin
            st_d.ov    = 1'b1;
            st_d.od    = sel_byte;
            st_d.olast = sel_last;
        end

        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid && req_ready) begin
                    acc_clr = 1'b1;
                    if (req_ok) begin
                        st_d.phase    = PH_SYNC0;
                        st_d.kind     = kind_e'(req_kind);
                        st_d.has_stat = req_has_stat;
                        st_d.cnt      = req_cnt;
                        st_d.rem      = req_len;
                    end
                end
            end
            PH_SYNC0: if (fire) st_d.phase = PH_SYNC1;
            PH_SYNC1: if (fire) st_d.phase = PH_ID;
            PH_ID:    if (fire) st_d.phase = PH_CNT;
            PH_CNT: begin
                if (fire) begin
                    if (st_q.rem != '0) begin
                        st_d.phase = PH_PAY;
                    end else if (st_q.has_stat) begin
                        st_d.phase = PH_STAT;
                    end else begin
                        st_d.phase = PH_CK1;
                    end
                end
            end
            PH_PAY: begin
                if (fire) begin
                    st_d.rem = st_q.rem - 1'b1;
                    if (st_q.rem == 8'd1) begin
                        st_d.phase = st_q.has_stat ? PH_STAT : PH_CK1;
                    end
                end
            end
            PH_STAT:  if (fire) st_d.phase = PH_CK1;
            PH_CK1:   if (fire) st_d.phase = PH_CK2;
            PH_CK2:   if (fire) st_d.phase = PH_IDLE;
            default:  st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.kind  <= KIND_NAV_SENSOR;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sensor_pkt_framer_chk.sv
module sensor_pkt_framer_chk
    import sensor_pkt_pkg::*;
#(
    parameter byte_t SYNC_A = 8'h81,
    parameter byte_t SYNC_B = 8'hA1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        pay_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [7:0]  out_data,
    input logic        out_last
);

    // position of the next output byte inside the frame, saturating at 2
    logic [1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= 2'd0;
        end else if (out_valid && out_ready) begin
            if (out_last) begin
                idx_q <= 2'd0;
            end else if (idx_q != 2'd2) begin
                idx_q <= idx_q + 2'd1;
            end
        end
    end

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid); // R6
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_data) && $stable(out_last)); // R6
    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R9
    AST_PAY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> (!out_valid || out_ready)); // R11
    AST_REQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!out_valid && !pay_ready)); // R8
    AST_FIRST_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (idx_q == 2'd0) |-> out_data == SYNC_A); // R2
    AST_SECOND_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (idx_q == 2'd1) |-> out_data == SYNC_B); // R2

endmodule

bind sensor_pkt_framer sensor_pkt_framer_chk #(
    .SYNC_A (SYNC_A),
    .SYNC_B (SYNC_B)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .pay_ready (pay_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/sensor_pkt_framer_tb_top.sv
module sensor_pkt_framer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = 2'd0;
    logic [7:0] req_len = 8'd0;
    logic       pay_valid = 1'b0;
    logic       pay_ready;
    logic [7:0] pay_data = 8'd0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_last;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0] exp_q[$];
    bit         lastq[$];
    string      tagq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sensor_pkt_framer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_len   (req_len),
        .pay_valid (pay_valid),
        .pay_ready (pay_ready),
        .pay_data  (pay_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(logic [7:0] b, bit last, string tag);
        exp_q.push_back(b);
        lastq.push_back(last);
        tagq.push_back(tag);
    endtask

    // consumer back-pressure
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = stall_mode ? lfsr[0] : 1'b1;
        end
    end

    // monitor / scoreboard
    bit         hold_chk = 1'b0;
    logic [7:0] hold_data;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (hold_chk) begin
                    check(out_valid && out_data == hold_data, "R6 stalled byte held",
                          {out_valid, out_data}, {1'b1, hold_data});
                    hold_chk = 1'b0;
                end
                if (out_valid && !out_ready) begin
                    hold_chk  = 1'b1;
                    hold_data = out_data;
                end
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3/R10 unexpected output byte", out_data, 0);
                    end else begin
                        logic [7:0] e;
                        bit el;
                        string t;
                        e  = exp_q.pop_front();
                        el = lastq.pop_front();
                        t  = tagq.pop_front();
                        check(out_data == e, t, out_data, e);
                        check(out_last == el, "R9 out_last", out_last, el);
                    end
                end
            end
        end
    end

    function automatic logic [7:0] pbyte(int seed, int i);
        return 8'(seed + i * 37 + (i >> 2));
    endfunction

    task automatic send_frame(int kind, int len, int seed, bit gaps, string rtag);
        bit valid;
        bit stat;
        logic [7:0] s1, s2, idb, cnt, stb, b;
        valid = (kind != 3) && !((kind != 0) && len == 255);
        stat  = (kind == 1) || (kind == 2);
        if (valid) begin
            idb = (kind == 0) ? 8'h01 : (kind == 1) ? 8'h02 : 8'h03;
            cnt = 8'(len + (stat ? 1 : 0));
            stb = (kind == 1) ? 8'h03 : 8'h07;
            s1 = 8'h00;
            s2 = 8'h00;
            push(8'h81, 1'b0, {rtag, " sync0"});
            push(8'hA1, 1'b0, {rtag, " sync1"});
            push(idb, 1'b0, "R3 identifier");
            s1 = s1 + idb; s2 = s2 + s1;
            push(cnt, 1'b0, "R4 count byte");
            s1 = s1 + cnt; s2 = s2 + s1;
            for (int i = 0; i < len; i++) begin
                b = pbyte(seed, i);
                push(b, 1'b0, {rtag, " payload"});
                s1 = s1 + b; s2 = s2 + s1;
            end
            if (stat) begin
                push(stb, 1'b0, "R4 status byte");
                s1 = s1 + stb; s2 = s2 + s1;
            end
            push(s1, 1'b0, {rtag, "/R5 checksum1"});
            push(s2, 1'b1, {rtag, "/R5 checksum2"});
        end
        @(posedge clk); #2;
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_len   = 8'(len);
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #2;
        req_valid = 1'b0;
        @(negedge clk);
        if (valid) begin
            check(req_ready == 1'b0, "R8 busy after accept", req_ready, 0);
            for (int i = 0; i < len; i++) begin
                @(posedge clk); #2;
                if (gaps && (i % 3 == 1)) begin
                    @(posedge clk); #2;
                end
                pay_valid = 1'b1;
                pay_data  = pbyte(seed, i);
                do @(negedge clk); while (!pay_ready);
                @(posedge clk); #2;
                pay_valid = 1'b0;
            end
            wait (exp_q.size() == 0);
            repeat (3) @(negedge clk);
            check(req_ready == 1'b1, "R8 ready after last", req_ready, 1);
        end else begin
            repeat (12) @(negedge clk);
            check(out_valid == 1'b0, {rtag, " rejected no output"}, out_valid, 0);
            check(req_ready == 1'b1, {rtag, " ready after reject"}, req_ready, 1);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(req_ready == 1'b1, "R1 req_ready in reset", req_ready, 1);
        check(pay_ready == 1'b0, "R1 pay_ready in reset", pay_ready, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(pay_ready == 1'b0, "R11 no pay_ready while idle", pay_ready, 0);

        send_frame(0, 3, 8'h10, 1'b0, "R2");
        send_frame(1, 2, 8'h55, 1'b0, "R2");
        send_frame(2, 6, 8'hC3, 1'b1, "R2");
        send_frame(0, 0, 8'h00, 1'b0, "R7");
        send_frame(1, 0, 8'h00, 1'b0, "R7");
        send_frame(2, 0, 8'h00, 1'b0, "R7");
        send_frame(3, 4, 8'h22, 1'b0, "R3");
        send_frame(1, 255, 8'h33, 1'b0, "R10");
        send_frame(2, 255, 8'h34, 1'b0, "R10");

        stall_mode = 1'b1;
        send_frame(0, 9, 8'h7E, 1'b1, "R6");
        send_frame(2, 4, 8'hF0, 1'b0, "R6");
        send_frame(1, 0, 8'h00, 1'b0, "R7");
        send_frame(0, 255, 8'hB5, 1'b1, "R2");
        send_frame(1, 254, 8'h4D, 1'b0, "R4");
        stall_mode = 1'b0;

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule